// File: doc/BRIEF.md
# Write-Protected GPIO Pin Bank Controller

This block controls a bank of general-purpose pins through a small memory-mapped register port. Every pin carries seven control bits spread over seven register groups: a function select that hands the pin to a peripheral multiplexer or keeps it for GPIO-side use, an owner select that picks between an I/O-processor path and the CPU, a CPU output enable, a CPU output value, an input polarity flip, an output polarity flip and an open-drain enable. An eighth group reports the synchronized pad levels.

Each 32-bit control word protects itself against stray writes. Its upper half is a write mask and its lower half holds sixteen pin bits. A write changes a pin bit only when the mask bit sixteen positions above it is 1 in the same write. Software therefore sets or clears single pins without first reading the word back. Each group holds up to eight words, so one group covers up to 128 pins.

On the pad side, each pin selects its enable and data source from the CPU registers, the I/O-processor inputs or the peripheral-mux inputs. The output flip and the open-drain rule are then applied. Pad inputs are synchronized and can be inverted before software or the owners see them.

Top module: `pin_bank_ctl`

## Requirements
- R1: A write to a control word sets pin bit n of that word when write-data bit n+16 is 1 and bit n is 1. It clears pin bit n when bit n+16 is 1 and bit n is 0. The new value is readable on the next access.
- R2: A pin bit whose mask bit (n+16) is 0 in a write keeps its previous value.
- R3: A read returns the sixteen pin bits of the addressed word in bits 15:0 and zeros in bits 31:16, one cycle after the read is issued. A word index beyond the pin count reads as zero.
- R4: The input group (group 3) reports each pad level after a two-flop synchronizer, XORed with that pin's input-flip bit. Writes to the input group have no effect. The same values drive `pin_in`.
- R5: After reset every control bit is 0. Every pin is therefore on the peripheral-mux path with no flips and no open-drain, and reads of control words return 0.
- R6: A pin whose function bit is 1 and whose owner bit is 1 drives `pad_oe` from its CPU output-enable bit and the pad data from its CPU output-value bit.
- R7: A pin whose function bit is 0 follows `mux_oe`/`mux_do`. A pin whose function bit is 1 and whose owner bit is 0 follows `iop_oe`/`iop_do`. In both cases the CPU enable and value bits have no effect.
- R8: A set output-flip bit inverts the selected data before the pad, whatever path owns the pin.
- R9: With open-drain set, a pin never drives high. When its data after the flip is 1, `pad_oe` is 0. When that data is 0, `pad_oe` follows the selected enable and `pad_do` is 0.
- R10: Byte address bits 7:5 select the group: 0 owner, 1 output enable, 2 output value, 3 input, 4 input flip, 5 output flip, 6 open-drain, 7 function select. Bits 4:2 select the word, which covers pins 16*word to 16*word+15. An access with address bits 1:0 not both 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data: mask in 31:16, pin bits in 15:0 |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| mux_oe | input | NUM_PINS | Peripheral-mux output enables |
| mux_do | input | NUM_PINS | Peripheral-mux output data |
| iop_oe | input | NUM_PINS | I/O-processor output enables |
| iop_do | input | NUM_PINS | I/O-processor output data |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_oe | output | NUM_PINS | Pad driver enables |
| pad_do | output | NUM_PINS | Pad driver data |
| pin_in | output | NUM_PINS | Synchronized, optionally inverted pad levels |

## Verification
The hardest case to reach from the ports is a pin where the owner selection, the output flip and open-drain act together. An open-drain pin must release the pad when its flipped data goes high, and a flip must also reach a pin that the CPU does not own. The stimulus builds this state one masked write at a time. It first hands a pin to the CPU and drives it. It then sets the flip and open-drain bits and finally removes the flip, checking the pad pins after every step. It also gives an I/O-processor pin CPU enable and value bits that contradict the owner inputs, which shows that the CPU bits are ignored. Partial-mask writes, with the same pin bits sent with and without their mask bits, show that a clear mask preserves the stored bit.

// File: rtl/pin_bank_pkg.sv
// Package: shared constants and the register-group encoding for the pin bank.
// Assumes byte addressing with 32-bit words and sixteen pins per word.
package pin_bank_pkg;
    localparam int HALF_W    = 16;  // pin bits per word; the mask sits this far above
    localparam int MAX_WORDS = 8;   // word index is three address bits
    localparam int GRP_COUNT = 8;

    typedef enum logic [2:0] {
        GRP_OWNER = 3'd0,
        GRP_OE    = 3'd1,
        GRP_OUT   = 3'd2,
        GRP_IN    = 3'd3,
        GRP_IINV  = 3'd4,
        GRP_OINV  = 3'd5,
        GRP_OD    = 3'd6,
        GRP_FSEL  = 3'd7
    } grp_e;
endpackage

// File: rtl/pin_bank_mask_reg.sv
// Module: one control group of pin bits written through the mask-half scheme.
// Assumes wr_en is already qualified by group decode; word index picks the
// sixteen-pin slice; every stored bit resets to zero.
module pin_bank_mask_reg
    import pin_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2:0]          wr_word,
    input  logic [31:0]         wdata,
    output logic [NUM_PINS-1:0] q
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
        localparam int          BIT_POS  = i % HALF_W;
        localparam logic [2:0]  BIT_WORD = 3'(i / HALF_W);

        // Update this pin bit only when its word is hit and its mask bit is set.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else if (wr_en && wr_word == BIT_WORD && wdata[BIT_POS + HALF_W]) begin
                q[i] <= wdata[BIT_POS];
            end
        end
    end
endmodule

// File: rtl/pin_bank_in_sync.sv
// Module: two-flop synchronizer for the pad inputs, followed by the input flip.
// Assumes pad_in is asynchronous; the flip bits act after the second flop.
module pin_bank_in_sync #(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pad_in,
    input  logic [NUM_PINS-1:0] flip,
    output logic [NUM_PINS-1:0] level
);
    logic [NUM_PINS-1:0] meta_q;
    logic [NUM_PINS-1:0] sync_q;

    // Two register stages to settle asynchronous pad levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= pad_in;
            sync_q <= meta_q;
        end
    end

    // Apply the per-pin input polarity.
    always_comb begin
        level = sync_q ^ flip;
    end
endmodule

// File: rtl/pin_bank_pad_drive.sv
// Module: per-pin source selection, output flip and open-drain rule.
// Assumes all control inputs come from registers; the path is combinational.
module pin_bank_pad_drive #(
    parameter int NUM_PINS = 32
) (
    input  logic [NUM_PINS-1:0] fsel,
    input  logic [NUM_PINS-1:0] owner,
    input  logic [NUM_PINS-1:0] cpu_oe,
    input  logic [NUM_PINS-1:0] cpu_do,
    input  logic [NUM_PINS-1:0] iop_oe,
    input  logic [NUM_PINS-1:0] iop_do,
    input  logic [NUM_PINS-1:0] mux_oe,
    input  logic [NUM_PINS-1:0] mux_do,
    input  logic [NUM_PINS-1:0] oflip,
    input  logic [NUM_PINS-1:0] odrain,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_do
);
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic src_oe;
        logic src_do;
        logic drv_d;

        // Pick the owner of the pin: peripheral mux, I/O processor or CPU.
        always_comb begin
            if (!fsel[i]) begin
                src_oe = mux_oe[i];
                src_do = mux_do[i];
            end else if (!owner[i]) begin
                src_oe = iop_oe[i];
                src_do = iop_do[i];
            end else begin
                src_oe = cpu_oe[i];
                src_do = cpu_do[i];
            end
        end

        // Flip the data, then release the pad for a high level under open-drain.
        always_comb begin
            drv_d     = src_do ^ oflip[i];
            pad_oe[i] = src_oe & ~(odrain[i] & drv_d);
            pad_do[i] = drv_d & ~odrain[i];
        end
    end
endmodule

// File: rtl/pin_bank_ctl.sv
// Module: top of the pin bank controller with register port, control groups,
// input synchronizer and pad drivers.
// Assumes one access per bus_sel cycle; read data appears one cycle later.
module pin_bank_ctl
    import pin_bank_pkg::*;
#(
    parameter int NUM_PINS = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [7:0]          bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic [NUM_PINS-1:0] mux_oe,
    input  logic [NUM_PINS-1:0] mux_do,
    input  logic [NUM_PINS-1:0] iop_oe,
    input  logic [NUM_PINS-1:0] iop_do,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_do,
    output logic [NUM_PINS-1:0] pin_in
);
    localparam int PAD_W = MAX_WORDS * HALF_W;

    logic [GRP_COUNT-1:0][NUM_PINS-1:0] ctl;
    logic [NUM_PINS-1:0] q_own, q_oe, q_out, q_iinv, q_oinv, q_od, q_fsel;
    logic                acc_ok;
    grp_e                acc_grp;
    logic [2:0]          acc_word;
    logic [PAD_W-1:0]    rd_vec;

    // Decode the access: aligned only, group and word from the address.
    always_comb begin
        acc_ok   = bus_sel && (bus_addr[1:0] == 2'b00);
        acc_grp  = grp_e'(bus_addr[7:5]);
        acc_word = bus_addr[4:2];
    end

    for (genvar g = 0; g < GRP_COUNT; g++) begin : g_grp
        if (g == int'(GRP_IN)) begin : g_input
            assign ctl[g] = pin_in;
        end else begin : g_ctl
            pin_bank_mask_reg #(.NUM_PINS(NUM_PINS)) i_reg (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (acc_ok && bus_wr && acc_grp == grp_e'(g)),
                .wr_word (acc_word),
                .wdata   (bus_wdata),
                .q       (ctl[g])
            );
        end
    end

    assign q_own  = ctl[GRP_OWNER];
    assign q_oe   = ctl[GRP_OE];
    assign q_out  = ctl[GRP_OUT];
    assign q_iinv = ctl[GRP_IINV];
    assign q_oinv = ctl[GRP_OINV];
    assign q_od   = ctl[GRP_OD];
    assign q_fsel = ctl[GRP_FSEL];

    pin_bank_in_sync #(.NUM_PINS(NUM_PINS)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .flip   (q_iinv),
        .level  (pin_in)
    );

    pin_bank_pad_drive #(.NUM_PINS(NUM_PINS)) i_drive (
        .fsel   (q_fsel),
        .owner  (q_own),
        .cpu_oe (q_oe),
        .cpu_do (q_out),
        .iop_oe (iop_oe),
        .iop_do (iop_do),
        .mux_oe (mux_oe),
        .mux_do (mux_do),
        .oflip  (q_oinv),
        .odrain (q_od),
        .pad_oe (pad_oe),
        .pad_do (pad_do)
    );

    // Widen the addressed group to the full word range; missing pins read zero.
    always_comb begin
        rd_vec                 = '0;
        rd_vec[NUM_PINS-1:0]   = ctl[acc_grp];
    end

    // Register the read word with a zero mask half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (acc_ok && !bus_wr) begin
            bus_rdata <= {16'h0000, rd_vec[acc_word*HALF_W +: HALF_W]};
        end
    end
endmodule

// File: rtl/pin_bank_ctl_chk.sv
// Module: property checker for pin_bank_ctl, attached with bind.
// Assumes it observes the top's ports and its group register outputs.
module pin_bank_ctl_chk #(
    parameter int NUM_PINS = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_sel,
    input logic                bus_wr,
    input logic [7:0]          bus_addr,
    input logic [31:0]         bus_wdata,
    input logic [31:0]         bus_rdata,
    input logic [NUM_PINS-1:0] pad_in,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_do,
    input logic [NUM_PINS-1:0] mux_oe,
    input logic [NUM_PINS-1:0] mux_do,
    input logic [NUM_PINS-1:0] pin_in,
    input logic [NUM_PINS-1:0] q_out,
    input logic [NUM_PINS-1:0] q_od,
    input logic [NUM_PINS-1:0] q_oinv,
    input logic [NUM_PINS-1:0] q_fsel,
    input logic [NUM_PINS-1:0] q_iinv
);
    logic [1:0] since_rst;
    logic       out0_wr;

    // Count cycles since reset, saturating once the synchronizer is full.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    assign out0_wr = bus_sel && bus_wr && bus_addr == 8'h40;

    AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        out0_wr && bus_wdata[16] |=> q_out[0] == $past(bus_wdata[0])); // R1
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out0_wr && !bus_wdata[16] |=> $stable(q_out[0])); // R2
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'h0000); // R3
    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        since_rst == 2'd2 |-> pin_in[0] == ($past(pad_in[0], 2) ^ q_iinv[0])); // R4
    AST_MUX_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !q_fsel[0] && !q_od[0] && !q_oinv[0] |-> pad_oe[0] == mux_oe[0] && pad_do[0] == mux_do[0]); // R7
    AST_OD_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (q_od & pad_oe & pad_do) == '0); // R9
endmodule

bind pin_bank_ctl pin_bank_ctl_chk #(.NUM_PINS(NUM_PINS)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pad_in    (pad_in),
    .pad_oe    (pad_oe),
    .pad_do    (pad_do),
    .mux_oe    (mux_oe),
    .mux_do    (mux_do),
    .pin_in    (pin_in),
    .q_out     (q_out),
    .q_od      (q_od),
    .q_oinv    (q_oinv),
    .q_fsel    (q_fsel),
    .q_iinv    (q_iinv)
);

// File: tb/test_pin_bank_ctl.sv
// Bench: scoreboard for reads (driver queues expected words, monitor compares)
// plus direct checks of the pad pins after each control change.
module test_pin_bank_ctl;
    localparam int NP = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] mux_oe = '0, mux_do = '0, iop_oe = '0, iop_do = '0, pad_in = '0;
    logic [NP-1:0] pad_oe, pad_do, pin_in;

    int checks = 0;
    int errors = 0;
    logic rd_fire = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    pin_bank_ctl #(.NUM_PINS(NP)) i_pin_bank_ctl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mux_oe(mux_oe), .mux_do(mux_do), .iop_oe(iop_oe), .iop_do(iop_do),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do), .pin_in(pin_in)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: note a read at the edge, compare the registered data half a cycle later.
    always @(posedge clk) rd_fire <= rst_n && bus_sel && !bus_wr;
    always @(negedge clk) begin
        if (rd_fire) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL scoreboard: read with no expected item, got %h expected none", bus_rdata);
            end else begin
                chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp); tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    initial begin : watchdog
        #1600000;
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R5: reset state
        chk(32'(pad_oe), 32'h0, "R5 pad_oe after reset");
        rd(8'h40, 32'h0, "R5 out word after reset");
        // R1: set through mask, then clear two bits
        wr(8'h40, 32'h00FF_00A5);
        rd(8'h40, 32'h0000_00A5, "R1 masked set");
        wr(8'h40, 32'h0003_0000);
        rd(8'h40, 32'h0000_00A4, "R1 masked clear");
        // R2: no mask bits, no change
        wr(8'h40, 32'h0000_FFFF);
        rd(8'h40, 32'h0000_00A4, "R2 mask clear preserves");
        // R10: second word, misaligned write ignored
        wr(8'h44, 32'hFFFF_1234);
        rd(8'h44, 32'h0000_1234, "R10 word 1 of out group");
        wr(8'h41, 32'hFFFF_FFFF);
        rd(8'h40, 32'h0000_00A4, "R10 misaligned write ignored");
        // R3: word beyond pin count
        rd(8'h48, 32'h0, "R3 word past pin count");
        // R4: synchronized inputs, read-only group, input flip
        pad_in = 32'h8000_0001;
        repeat (3) @(negedge clk);
        rd(8'h60, 32'h0000_0001, "R4 input word 0");
        rd(8'h64, 32'h0000_8000, "R4 input word 1");
        wr(8'h60, 32'hFFFF_FFFE);
        rd(8'h60, 32'h0000_0001, "R4 input write ignored");
        wr(8'h80, 32'h0001_0001);
        rd(8'h60, 32'h0000_0000, "R4 input flip");
        chk(32'(pin_in[0]), 32'h0, "R4 pin_in flipped");
        // R7: reset routes pin 4 to the mux
        mux_oe = '1; mux_do = '1;
        @(negedge clk);
        chk(32'({pad_oe[4], pad_do[4]}), 32'h3, "R7 mux path pin 4");
        // R6: pins 0-3 GPIO side, 0-1 CPU owned
        wr(8'hE0, 32'h000F_000F);
        wr(8'h00, 32'h0003_0003);
        wr(8'h20, 32'h0001_0001);
        chk(32'({pad_oe[0], pad_do[0]}), 32'h2, "R6 cpu oe=1 out=0");
        chk(32'(pad_oe[1]), 32'h0, "R6 cpu oe=0");
        wr(8'h40, 32'h0001_0001);
        chk(32'({pad_oe[0], pad_do[0]}), 32'h3, "R6 cpu out=1");
        // R7: pin 2 IOP owned, CPU out bit is 1 but must be ignored
        chk(32'(pad_oe[2]), 32'h0, "R7 iop oe=0");
        iop_oe = 32'h0000_0004; iop_do = 32'h0;
        @(negedge clk);
        chk(32'({pad_oe[2], pad_do[2]}), 32'h2, "R7 iop drives 0");
        // R8: output flip on CPU pin and on mux pin
        wr(8'hA0, 32'h0011_0011);
        chk(32'(pad_do[0]), 32'h0, "R8 flip cpu pin");
        chk(32'({pad_oe[4], pad_do[4]}), 32'h2, "R8 flip mux pin");
        // R9: open drain; data after flip is 0 then 1
        wr(8'hC0, 32'h0001_0001);
        chk(32'({pad_oe[0], pad_do[0]}), 32'h2, "R9 od drives low");
        wr(8'hA0, 32'h0001_0000);
        chk(32'({pad_oe[0], pad_do[0]}), 32'h0, "R9 od releases high");
        // R10: group offsets read back
        rd(8'hC0, 32'h0000_0001, "R10 open-drain group");
        rd(8'h00, 32'h0000_0003, "R10 owner group");
        rd(8'hE0, 32'h0000_000F, "R10 function group");
        rd(8'hA0, 32'h0000_0010, "R10 output flip group");
        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule